// File: doc/BRIEF.md
# Cascadable Four-Channel Audio Divider

This block produces the timing pulses for a four-voice retro sound generator. It has four 8-bit programmable dividers, numbered channel 1 to channel 4. Each channel counts ticks of a selected clock source and emits a one-cycle pulse each time its count runs out. A configuration byte sets three things: the shared base clock (the master clock divided by 28 or by 120), whether channels 1 and 3 run straight from the master clock, and whether the channels are joined in pairs (1 with 2, 3 with 4) into 16-bit dividers. Noise shaping, volume and mixing stages downstream use the pulses. Channels 1, 2 and 4 also raise an interrupt request each time they pulse.

Software programs the block through a simple write port. It loads the four divider values and the configuration byte. It then writes a non-zero value to the restart location, which reloads every counter and the base prescaler so that all channels start in phase. Each channel pair runs in one of two modes. In PAIR_SPLIT, both channels divide on their own, and the high channel always runs from the base clock. In PAIR_JOINED, the low channel becomes the low byte of a 16-bit count and borrows from the high byte; only the high channel pulses. The low channel of a pair picks its tick from two sources: SRC_BASE (the prescaler tick) or SRC_MASTER (every master clock cycle). The configuration register selects the mode of each pair and the source of its low channel. A change of configuration takes effect from the clock cycle after the write.

Top module: `audio_divider_quad`

## Requirements
- R1: A write stores its data by address: 0 loads channel 1's value, 2 loads channel 2, 4 loads channel 3, 6 loads channel 4, and 8 loads the configuration byte. Address 9 is the restart location. Writes to other addresses have no effect.
- R2: With configuration bit 0 set, the base tick comes every 120 master clocks; with it clear, every 28. After a restart, the first base tick falls 28 (or 120) cycles after the restart edge.
- R3: A channel in PAIR_SPLIT mode with value V on base ticks pulses for one cycle once every (V+1) ticks. Its first pulse follows the restart edge by (V+1) times the base ratio.
- R4: Configuration bit 6 puts channel 1 on SRC_MASTER, and bit 5 does the same for channel 3. A channel on SRC_MASTER with value V pulses every V+1 master clocks; V=0 gives a pulse on every cycle.
- R5: Configuration bit 4 joins channels 1 and 2, and bit 3 joins channels 3 and 4. A joined pair counts the 16-bit value high*256+low on its low channel's source and pulses on the high channel every (value+1) ticks. The low channel never pulses while joined.
- R6: A write of a non-zero value to address 9 reloads all four counters from their registers, clears the prescaler, and clears every pulse output on that edge.
- R7: A write of zero to address 9 has no effect on any counter or pulse timing.
- R8: irq_req bit 0 follows channel 1's pulse, bit 1 follows channel 2's, and bit 2 follows channel 4's, in the same cycle.
- R9: While reset is asserted and just after it is released, all pulse and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| pulse_out | output | 4 | One-cycle divider output pulses, bit 0 = channel 1 |
| irq_req | output | 3 | Zero-reached requests for channels 1, 2, 4 |

## Verification
The assertions assume that the configuration register changes only through a write. Their pulse-spacing and silent-low-channel properties therefore skip any cycle in which wr_en is high, because a new configuration takes effect one edge after the write. The bench writes the values and the configuration, then issues a restart. It then holds the configuration fixed for the whole measuring window. The only write inside the window is a zero restart strobe, which the assertions also skip. Each window runs until every active channel has pulsed at least twice, so both the first-pulse cycle and the pulse count can be checked against periods the bench computes from the written values.

// File: rtl/adiv_pkg.sv
package adiv_pkg;

    localparam int CHANNELS = 4;
    localparam int PAIRS    = CHANNELS / 2;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int IRQ_W    = 3;

    localparam logic [ADDR_W-1:0] ADDR_CFG     = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] ADDR_RESTART = ADDR_W'(9);

    localparam int CFG_SLOW_BASE = 0;
    localparam int CFG_JOIN34    = 3;
    localparam int CFG_JOIN12    = 4;
    localparam int CFG_FAST3     = 5;
    localparam int CFG_FAST1     = 6;

    typedef enum logic {
        SRC_BASE   = 1'b0,
        SRC_MASTER = 1'b1
    } clk_src_t;

    typedef enum logic {
        PAIR_SPLIT  = 1'b0,
        PAIR_JOINED = 1'b1
    } pair_mode_t;

endpackage

// File: rtl/adiv_regs.sv
module adiv_regs
    import adiv_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [CHANNELS-1:0][DATA_W-1:0]   div_val,
    output logic [DATA_W-1:0]                 cfg,
    output logic                              restart
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_val <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < CHANNELS; i++) begin
                if (wr_addr == ADDR_W'(2 * i)) begin
                    div_val[i] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && wr_addr == ADDR_CFG) begin
            cfg <= wr_data;
        end
    end

    assign restart = wr_en && (wr_addr == ADDR_RESTART) && (|wr_data);

endmodule

// File: rtl/adiv_prescaler.sv
module adiv_prescaler #(
    parameter int FAST_DIV = 28,
    parameter int SLOW_DIV = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow_sel,
    output logic tick
);

    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW      = $clog2(MAX_DIV);

    logic [CW-1:0] count_q;
    logic [CW-1:0] last_value;

    assign last_value = slow_sel ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
    assign tick       = (count_q >= last_value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart || tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/adiv_pair.sv
module adiv_pair
    import adiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             base_tick,
    input  pair_mode_t       mode,
    input  clk_src_t         lo_src,
    input  logic [DIV_W-1:0] lo_val,
    input  logic [DIV_W-1:0] hi_val,
    output logic             pulse_lo,
    output logic             pulse_hi
);

    logic [DIV_W-1:0] lo_cnt, hi_cnt;
    logic [DIV_W-1:0] lo_nxt, hi_nxt;
    logic             lo_uf, hi_uf;
    logic             lo_en;

    assign lo_en = (lo_src == SRC_MASTER) || base_tick;

    always_comb begin
        lo_nxt = lo_cnt;
        hi_nxt = hi_cnt;
        lo_uf  = 1'b0;
        hi_uf  = 1'b0;
        unique case (mode)
            PAIR_SPLIT: begin
                if (lo_en) begin
                    if (lo_cnt == '0) begin
                        lo_nxt = lo_val;
                        lo_uf  = 1'b1;
                    end else begin
                        lo_nxt = lo_cnt - 1'b1;
                    end
                end
                if (base_tick) begin
                    if (hi_cnt == '0) begin
                        hi_nxt = hi_val;
                        hi_uf  = 1'b1;
                    end else begin
                        hi_nxt = hi_cnt - 1'b1;
                    end
                end
            end
            PAIR_JOINED: begin
                if (lo_en) begin
                    if (lo_cnt == '0 && hi_cnt == '0) begin
                        lo_nxt = lo_val;
                        hi_nxt = hi_val;
                        hi_uf  = 1'b1;
                    end else if (lo_cnt == '0) begin
                        lo_nxt = '1;
                        hi_nxt = hi_cnt - 1'b1;
                    end else begin
                        lo_nxt = lo_cnt - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt   <= '0;
            hi_cnt   <= '0;
            pulse_lo <= 1'b0;
            pulse_hi <= 1'b0;
        end else if (restart) begin
            lo_cnt   <= lo_val;
            hi_cnt   <= hi_val;
            pulse_lo <= 1'b0;
            pulse_hi <= 1'b0;
        end else begin
            lo_cnt   <= lo_nxt;
            hi_cnt   <= hi_nxt;
            pulse_lo <= lo_uf;
            pulse_hi <= hi_uf;
        end
    end

endmodule

// File: rtl/audio_divider_quad.sv
module audio_divider_quad
    import adiv_pkg::*;
#(
    parameter int BASE_FAST_DIV = 28,
    parameter int BASE_SLOW_DIV = 120
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic [3:0]  pulse_out,
    output logic [2:0]  irq_req
);

    logic [CHANNELS-1:0][DATA_W-1:0] div_val;
    logic [DATA_W-1:0]               cfg_q;
    logic                            restart_hit;
    logic                            base_tick;

    adiv_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div_val (div_val),
        .cfg     (cfg_q),
        .restart (restart_hit)
    );

    adiv_prescaler #(
        .FAST_DIV (BASE_FAST_DIV),
        .SLOW_DIV (BASE_SLOW_DIV)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart_hit),
        .slow_sel (cfg_q[CFG_SLOW_BASE]),
        .tick     (base_tick)
    );

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            localparam int JOIN_BIT = (p == 0) ? CFG_JOIN12 : CFG_JOIN34;
            localparam int FAST_BIT = (p == 0) ? CFG_FAST1  : CFG_FAST3;

            pair_mode_t mode;
            clk_src_t   src;

            always_comb begin
                mode = cfg_q[JOIN_BIT] ? PAIR_JOINED : PAIR_SPLIT;
                src  = cfg_q[FAST_BIT] ? SRC_MASTER  : SRC_BASE;
            end

            adiv_pair #(
                .DIV_W (DATA_W)
            ) u_pair (
                .clk       (clk),
                .rst_n     (rst_n),
                .restart   (restart_hit),
                .base_tick (base_tick),
                .mode      (mode),
                .lo_src    (src),
                .lo_val    (div_val[2*p]),
                .hi_val    (div_val[2*p+1]),
                .pulse_lo  (pulse_out[2*p]),
                .pulse_hi  (pulse_out[2*p+1])
            );
        end
    endgenerate

    assign irq_req = {pulse_out[3], pulse_out[1], pulse_out[0]};

endmodule

// File: rtl/adiv_checks.sv
module adiv_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] cfg,
    input logic       restart,
    input logic [3:0] pulse_out,
    input logic [2:0] irq_req
);

    // R3: a channel on base ticks never pulses two cycles in a row
    assert_ch1_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out[0] && !cfg[6] && !wr_en) |=> !pulse_out[0]);

    assert_ch2_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out[1] && !(cfg[4] && cfg[6]) && !wr_en) |=> !pulse_out[1]);

    assert_ch3_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out[2] && !cfg[5] && !wr_en) |=> !pulse_out[2]);

    assert_ch4_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out[3] && !(cfg[3] && cfg[5]) && !wr_en) |=> !pulse_out[3]);

    // R5: the low channel of a joined pair stays silent
    assert_low12_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[4] && !wr_en) |=> !pulse_out[0]);

    assert_low34_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[3] && !wr_en) |=> !pulse_out[2]);

    // R6: a restart clears every pulse and request on its edge
    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pulse_out == 4'b0000 && irq_req == 3'b000));

endmodule

bind audio_divider_quad adiv_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .cfg       (cfg_q),
    .restart   (restart_hit),
    .pulse_out (pulse_out),
    .irq_req   (irq_req)
);

// File: tb/audio_divider_quad_test.sv
module audio_divider_quad_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pulse_out;
    logic [2:0] irq_req;

    int n_cmp = 0;
    int n_bad = 0;

    audio_divider_quad uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out),
        .irq_req   (irq_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string msg, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int period_of(input int c, input logic [7:0] cf, input int vals[4]);
        int base = cf[0] ? 120 : 28;
        int s0   = cf[6] ? 1 : base;
        int s2   = cf[5] ? 1 : base;
        case (c)
            0: return cf[4] ? 0 : (vals[0] + 1) * s0;
            1: return cf[4] ? (vals[1] * 256 + vals[0] + 1) * s0 : (vals[1] + 1) * base;
            2: return cf[3] ? 0 : (vals[2] + 1) * s2;
            default: return cf[3] ? (vals[3] * 256 + vals[2] + 1) * s2 : (vals[3] + 1) * base;
        endcase
    endfunction

    function automatic string tag_of(input int c, input logic [7:0] cf);
        if ((c < 2 && cf[4]) || (c >= 2 && cf[3])) return "R5";
        if ((c == 0 && cf[6]) || (c == 2 && cf[5])) return "R4";
        return cf[0] ? "R2" : "R3";
    endfunction

    task automatic run(input logic [7:0] cf, input int v0, input int v1, input int v2,
                       input int v3, input bit zs, input string note);
        int vals[4];
        int per[4];
        int first[4];
        int cnt[4];
        int limit;
        int irq_bad;
        string tag;
        vals = '{v0, v1, v2, v3};
        wr(4'd0, v0[7:0]);
        wr(4'd2, v1[7:0]);
        wr(4'd4, v2[7:0]);
        wr(4'd6, v3[7:0]);
        wr(4'd11, 8'hFF);        // unmapped address, R1: must not disturb anything
        wr(4'd8, cf);
        wr(4'd9, 8'hA5);         // restart edge, R6
        limit = 40;
        for (int c = 0; c < 4; c++) begin
            per[c]   = period_of(c, cf, vals);
            first[c] = 0;
            cnt[c]   = 0;
            if (2 * per[c] + 3 > limit) limit = 2 * per[c] + 3;
        end
        irq_bad = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                if (pulse_out[c]) begin
                    cnt[c]++;
                    if (first[c] == 0) first[c] = k;
                end
            end
            if (irq_req !== {pulse_out[3], pulse_out[1], pulse_out[0]}) irq_bad++;
            if (zs && k == 3) begin
                wr_en = 1'b1; wr_addr = 4'd9; wr_data = 8'h00;   // R7 zero restart
            end else if (zs && k == 4) begin
                wr_en = 1'b0;
            end
        end
        for (int c = 0; c < 4; c++) begin
            tag = $sformatf("%s%s cfg=%02h ch%0d", tag_of(c, cf), note, cf, c + 1);
            if (per[c] == 0) begin
                chk({tag, " silent low channel pulse count"}, cnt[c], 0);
            end else begin
                chk({tag, " R6 first pulse cycle"}, first[c], per[c]);
                chk({tag, " pulse count"}, cnt[c], limit / per[c]);
            end
        end
        chk($sformatf("R8 cfg=%02h irq mismatching cycles", cf), irq_bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 pulses in reset", int'(pulse_out), 0);
        chk("R9 irq in reset", int'(irq_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 pulses after reset", int'(pulse_out), 0);
        chk("R9 irq after reset", int'(irq_req), 0);

        run(8'h00, 0, 1, 5, 9, 1'b1, "/R1/R7");
        run(8'h01, 2, 0, 3, 7, 1'b0, "");
        run(8'h60, 0, 3, 255, 9, 1'b0, "");
        run(8'h20, 1, 1, 0, 2, 1'b0, "");
        run(8'h10, 8'h34, 8'h02, 4, 1, 1'b0, "");
        run(8'h78, 8'h05, 8'h01, 8'h00, 8'h10, 1'b0, "");
        run(8'h09, 7, 3, 8'h05, 8'h01, 1'b0, "");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule